// File: doc/BRIEF.md
# Ready/Busy Status Pin Generator

This block turns the activity indications of a program/erase controller into the enable for an open-drain status pin. When the enable is high the pin is pulled low. Because every device only ever pulls the line low, several devices can share one pull-up resistor. A low line then means that at least one of them is busy.

Two behaviours can be chosen by a command write. In level mode, the pin follows the controller's busy level. In pulse mode, the pin stays released and gives one low pulse of a fixed, parameterised width each time a program or block-erase operation completes, so that it can serve as an interrupt line. A mode write takes effect only while the controller is idle and no pulse is in flight, so the pin never glitches. During reset the pin is released, unless the controller was already active when reset arrived.

Top module: `stat_pin_top`

## Requirements
- R1: In the first cycle after reset is released, the block is in level mode and `pinLow` is 0.
- R2: In level mode and outside reset, `pinLow` equals the `peBusy` value of the previous cycle.
- R3: In level mode, `peDone` has no effect: `pinLow` keeps following the busy level alone.
- R4: In pulse mode, a `peDone` sampled on an edge makes `pinLow` 1 for exactly PULSE_W cycles starting right after that edge, and 0 afterwards. In this mode `peBusy` does not drive the pin.
- R5: In pulse mode, a `peDone` that arrives while a pulse is active restarts the pulse, so it lasts PULSE_W cycles from the later completion.
- R6: A mode write (`modeWr`=1) takes effect on the next edge if `peBusy` is 0 and no pulse is active. Otherwise it is held pending and applied on the first edge where both conditions hold. A later write replaces a pending one.
- R7: While `rstN` is 0, `pinLow` is 0 unless `peBusy` was 1 in the cycle before reset was asserted. In that case `pinLow` stays 1 while `peBusy` remains 1, and falls to 0 for the rest of that reset once `peBusy` drops.
- R8: The mode is encoded on `modeSel` as 0 for level mode and 1 for pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; also gates the pin directly |
| peBusy | input | 1 | Program/erase controller busy level |
| peDone | input | 1 | One-cycle strobe at the end of a program or block erase |
| modeWr | input | 1 | Mode-select command write strobe |
| modeSel | input | 1 | Mode value written with `modeWr` (0 level, 1 pulse) |
| pinLow | output | 1 | Open-drain enable: 1 pulls the status pin low |

## Verification
The bench drives the pin through several kinds of stimulus. A multi-cycle busy burst with stray completion strobes separates level tracking from pulse generation. A single completion and a pair of completions spaced closer than the pulse width separate a restarted pulse from one that is lost or merely overlapped. Mode writes are issued both while the controller is idle and while it is busy, which shows whether a switch is deferred rather than applied at once. Reset is asserted once with the controller idle and once with it busy, and busy is dropped mid-reset to show the release of a held pin.

// File: rtl/stat_pin_pkg.sv
package stat_pin_pkg;
  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_PULSE = 1'b1
  } pinMode_e;

  typedef struct packed {
    logic statusMode;
    logic loadPulse;
  } pinCtl_t;
endpackage

// File: rtl/stat_pin_ctrl.sv
module stat_pin_ctrl
  import stat_pin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    peBusy,
  input  logic    peDone,
  input  logic    modeWr,
  input  logic    modeSel,
  input  logic    pulseActive,
  output pinCtl_t ctl
);
  pinMode_e modeQ;
  pinMode_e pendModeQ;
  logic     pendValidQ;
  logic     idle;
  logic     wrReq;
  pinMode_e wrVal;

  assign idle  = !peBusy && !pulseActive;
  assign wrReq = modeWr || pendValidQ;
  assign wrVal = modeWr ? pinMode_e'(modeSel) : pendModeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= MODE_LEVEL;
      pendModeQ  <= MODE_LEVEL;
      pendValidQ <= 1'b0;
    end else if (wrReq && idle) begin
      modeQ      <= wrVal;
      pendValidQ <= 1'b0;
    end else if (modeWr) begin
      pendModeQ  <= pinMode_e'(modeSel);
      pendValidQ <= 1'b1;
    end
  end

  assign ctl.statusMode = (modeQ == MODE_PULSE);
  assign ctl.loadPulse  = (modeQ == MODE_PULSE) && peDone;
endmodule

// File: rtl/stat_pin_dp.sv
module stat_pin_dp
  import stat_pin_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    peBusy,
  input  pinCtl_t ctl,
  output logic    pulseActive,
  output logic    pinLow
);
  localparam int CNT_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PULSE_W);

  logic [CNT_W-1:0] cntQ;
  logic             busyQ;
  logic             holdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      busyQ <= 1'b0;
    end else begin
      busyQ <= peBusy;
      if (ctl.loadPulse)   cntQ <= FULL;
      else if (cntQ != '0) cntQ <= cntQ - 1'b1;
    end
  end

  // Keeps the pin held low through reset only while an operation that
  // was running at reset entry is still running.
  always_ff @(posedge clk) begin
    holdQ <= rstN ? peBusy : (holdQ && peBusy);
  end

  assign pulseActive = (cntQ != '0);

  always_comb begin
    if (!rstN)               pinLow = holdQ;
    else if (ctl.statusMode) pinLow = pulseActive;
    else                     pinLow = busyQ;
  end
endmodule

// File: rtl/stat_pin_top.sv
module stat_pin_top
  import stat_pin_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic peBusy,
  input  logic peDone,
  input  logic modeWr,
  input  logic modeSel,
  output logic pinLow
);
  pinCtl_t ctlBus;
  logic    pulseActive;
  logic    modeIsPulse;

  stat_pin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .peBusy(peBusy), .peDone(peDone),
    .modeWr(modeWr), .modeSel(modeSel), .pulseActive(pulseActive),
    .ctl(ctlBus)
  );

  stat_pin_dp #(.PULSE_W(PULSE_W)) u_dp (
    .clk(clk), .rstN(rstN), .peBusy(peBusy), .ctl(ctlBus),
    .pulseActive(pulseActive), .pinLow(pinLow)
  );

  assign modeIsPulse = ctlBus.statusMode;
endmodule

// File: rtl/stat_pin_chk.sv
module stat_pin_chk (
  input logic clk,
  input logic rstN,
  input logic peBusy,
  input logic peDone,
  input logic pinLow,
  input logic modeIsPulse
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r2_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rstN) && !modeIsPulse && !$past(modeIsPulse)) |-> (pinLow == $past(peBusy)));

  a_r4_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rstN) && modeIsPulse && $past(modeIsPulse) && $past(peDone)) |-> pinLow);

  a_r6_mode_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rstN) && $past(peBusy)) |-> $stable(modeIsPulse));

  a_r1_level_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(rstN)) |-> (!modeIsPulse && !pinLow));

  a_r7_reset_released: assert property (@(posedge clk)
    (armed && !rstN && !$past(rstN) && !$past(peBusy)) |-> !pinLow);
endmodule

bind stat_pin_top stat_pin_chk chk_i (
  .clk(clk), .rstN(rstN), .peBusy(peBusy), .peDone(peDone),
  .pinLow(pinLow), .modeIsPulse(modeIsPulse)
);

// File: tb/stat_pin_top_tb_top.sv
module stat_pin_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic peBusy = 1'b0;
  logic peDone = 1'b0;
  logic modeWr = 1'b0;
  logic modeSel = 1'b0;
  logic pinLow;

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R7";
  bit done = 1'b0;

  // behavioural reference state
  bit mMode = 0, mPendMode = 0, mPendValid = 0, mBusyQ = 0, mHold = 0;
  int mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_pin_top #(.PULSE_W(PULSE_W)) dut_i (
    .clk(clk), .rstN(rstN), .peBusy(peBusy), .peDone(peDone),
    .modeWr(modeWr), .modeSel(modeSel), .pinLow(pinLow)
  );

  task automatic check(input string req, input bit act, input bit exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: pinLow=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model and per-cycle compare
  always @(posedge clk) begin
    bit idle, nxtHold;
    nxtHold = rstN ? peBusy : (mHold && peBusy);
    if (!rstN) begin
      mMode = 0; mPendMode = 0; mPendValid = 0; mCnt = 0; mBusyQ = 0;
    end else begin
      idle = !peBusy && (mCnt == 0);
      if ((modeWr || mPendValid) && idle) begin
        mMode = modeWr ? modeSel : mPendMode;
        mPendValid = 0;
        if (mMode) mCnt = (mCnt > 0) ? mCnt - 1 : 0;
        else mCnt = (mCnt > 0) ? mCnt - 1 : 0;
      end else begin
        if (modeWr) begin mPendMode = modeSel; mPendValid = 1; end
        if (mMode && peDone) mCnt = PULSE_W;
        else if (mCnt > 0) mCnt--;
      end
      mBusyQ = peBusy;
    end
    mHold = nxtHold;
    #1;
    if (!done) check(curReq, pinLow, !rstN ? mHold : (mMode ? (mCnt != 0) : mBusyQ));
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobeDone();
    peDone = 1'b1; step(1); peDone = 1'b0;
  endtask

  task automatic writeMode(input bit v);
    modeSel = v; modeWr = 1'b1; step(1); modeWr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, expected completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R7: reset with idle controller keeps pin released
    curReq = "R7"; step(3);
    curReq = "R1"; rstN = 1'b1; step(1);
    #2 check("R1", pinLow, 1'b0);
    // R2: level follows busy
    curReq = "R2"; peBusy = 1'b1; step(3); #2 check("R2", pinLow, 1'b1);
    peBusy = 1'b0; step(2); #2 check("R2", pinLow, 1'b0);
    // R3: completion strobes ignored in level mode
    curReq = "R3"; strobeDone(); #2 check("R3", pinLow, 1'b0);
    step(2); strobeDone(); step(1);
    // R8 / R6: switch to pulse mode (1) while idle
    curReq = "R8"; writeMode(1'b1); step(1);
    // R4: busy ignored, single pulse
    curReq = "R4"; peBusy = 1'b1; step(2); #2 check("R4", pinLow, 1'b0);
    peBusy = 1'b0; strobeDone(); #2 check("R4", pinLow, 1'b1);
    step(PULSE_W - 1); #2 check("R4", pinLow, 1'b1);
    step(1); #2 check("R4", pinLow, 1'b0);
    step(2);
    // R5: second completion mid-pulse restarts it
    curReq = "R5"; strobeDone(); step(1); strobeDone();
    step(PULSE_W - 1); #2 check("R5", pinLow, 1'b1);
    step(1); #2 check("R5", pinLow, 1'b0);
    // R6: write during busy is deferred; last write wins
    curReq = "R6"; peBusy = 1'b1; step(1);
    writeMode(1'b0); writeMode(1'b1); writeMode(1'b0);
    strobeDone(); #2 check("R6", pinLow, 1'b1);
    step(PULSE_W + 2);
    peBusy = 1'b0; step(2);
    peBusy = 1'b1; step(2); #2 check("R6", pinLow, 1'b1);
    // R7: reset while busy holds pin until busy drops
    curReq = "R7"; rstN = 1'b0; step(1); #2 check("R7", pinLow, 1'b1);
    step(1); peBusy = 1'b0; step(1); #2 check("R7", pinLow, 1'b0);
    peBusy = 1'b1; step(2); #2 check("R7", pinLow, 1'b0);
    peBusy = 1'b0; step(1);
    curReq = "R1"; rstN = 1'b1; step(1); #2 check("R1", pinLow, 1'b0);
    strobeDone(); #2 check("R3", pinLow, 1'b0);
    step(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule